// File: doc/BRIEF.md
# SD Host Error Interrupt Status Register

This block holds the error half of an SD/SDIO host controller's interrupt status word, together with the small amount of logic that decides when each error bit sets. The command path, data path, DMA engine and timeout counters live elsewhere. They reach this block as single-cycle strobes and the values sampled alongside them: the response index, the end bit, the CRC check result, the 3-bit CRC status token returned after a block write, four timeout strobes, the descriptor valid flag, and the auto-CMD12 error vector.

Software reads the status word over a small register bus and clears bits by writing ones to them. A second register holds a per-bit interrupt enable mask. The interrupt line is high whenever a status bit and its enable bit are both set. All bus signals are plain control and status pins, so the bus has no handshake and no back-pressure. A write completes in the cycle it is presented, and read data is a combinational function of the address.

Top module: `sdh_err_status`

## Requirements
- R1: The status word, read at `bus_addr`=0, carries the DMA error at bit 25, auto-CMD12 error at bit 24, data end-bit error at bit 22, data CRC error at bit 21, data timeout at bit 20 and command index error at bit 19. Every other bit, including bit 23, always reads 0, even after writes or when every event is raised at once.
- R2: Each status bit is sticky. It is visible on the first clock edge after its event and holds until cleared. Writing a 1 to a bit at `bus_addr`=0 clears it. Writing a 0 leaves it unchanged.
- R3: The auto-CMD12 error sets when any bit of `acmd_err_vec` goes from 0 to 1 between consecutive cycles. A bit that stays at 1 does not set it again. After reset the previous vector is taken as all zeros.
- R4: The end-bit error sets when `rd_end_stb` is high with `rd_end_bit`=0. It also sets when `crcst_stb` is high with `crcst_end_bit`=0.
- R5: The CRC error sets when `rd_crc_stb` is high with `rd_crc_ok`=0. It also sets when `crcst_stb` is high and `crcst_tok` is not 3'b010.
- R6: The timeout bit sets on any of `to_busy_rsp`, `to_busy_wr`, `to_crcst` or `to_rd_data`.
- R7: The command index error sets when `rsp_stb` is high, `idx_chk_en` is 1 and `rsp_idx` differs from `cmd_idx`. It does not set when `idx_chk_en` is 0 or when the two indices match.
- R8: The DMA error sets on `dma_err_stb`. It also sets when `desc_stb` is high while `desc_fetch_st` is 1 and `desc_valid` is 0. An invalid descriptor seen outside the fetch state has no effect.
- R9: If a set event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R10: The enable mask is read and written at `bus_addr`=1, using the same bit positions as the status word. Only the six defined bits are stored, and the rest read 0. `irq` is the OR of status AND mask, combinational from the registers.
- R11: A synchronous active-high `rst` clears all status bits, the mask and the stored previous auto-CMD12 vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = status word, 1 = enable mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |
| rsp_stb | input | 1 | Response received |
| rsp_idx | input | IDX_W | Index field of the received response |
| cmd_idx | input | IDX_W | Index of the command last issued |
| idx_chk_en | input | 1 | Enables the command index check |
| rd_end_stb | input | 1 | End bit of read data sampled |
| rd_end_bit | input | 1 | Sampled read-data end bit |
| rd_crc_stb | input | 1 | CRC16 result of a read block ready |
| rd_crc_ok | input | 1 | CRC16 matched |
| crcst_stb | input | 1 | Write CRC status token received |
| crcst_tok | input | 3 | Received CRC status token |
| crcst_end_bit | input | 1 | End bit after the CRC status token |
| to_busy_rsp | input | 1 | Busy timeout after a busy-type response |
| to_busy_wr | input | 1 | Busy timeout after the write CRC status |
| to_crcst | input | 1 | Write CRC status timeout |
| to_rd_data | input | 1 | Read data timeout |
| acmd_err_vec | input | ACMD_W | Auto-CMD12 error flags |
| dma_err_stb | input | 1 | DMA transfer error |
| desc_stb | input | 1 | Descriptor fetched |
| desc_fetch_st | input | 1 | DMA engine is in its fetch-descriptor state |
| desc_valid | input | 1 | Valid flag of the fetched descriptor |

## Verification
A wrong internal state shows up on `bus_rdata` and `irq` one clock after the event that caused it. A missed set, a missed clear or a bit that falls on its own is visible at the very next status read. A stale or unreset previous copy of the auto-CMD12 vector makes that bit set on a level rather than an edge. This is seen as soon as the bench holds the vector steady after a clear. A mask register that stores the wrong bits shows in the mask readback, and also in `irq` the first time a status bit is set with its enable bit cleared.

// File: rtl/sdh_err_pkg.sv
package sdh_err_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned NERR   = 6;

  // compact error index
  localparam int unsigned E_CIDX = 0;
  localparam int unsigned E_TO   = 1;
  localparam int unsigned E_CRC  = 2;
  localparam int unsigned E_END  = 3;
  localparam int unsigned E_ACMD = 4;
  localparam int unsigned E_DMA  = 5;

  // bit position of each compact entry in the status word
  localparam int unsigned POS [NERR] = '{19, 20, 21, 22, 24, 25};

  localparam logic [2:0] CRCST_GOOD = 3'b010;

  typedef logic [NERR-1:0]   err_vec_t;
  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t expand(input err_vec_t v);
    word_t w;
    w = '0;
    for (int i = 0; i < NERR; i++) w[POS[i]] = v[i];
    return w;
  endfunction

  localparam word_t DEF_MASK = expand('1);

endpackage

// File: rtl/sdh_err_detect.sv
module sdh_err_detect
  import sdh_err_pkg::*;
#(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned ACMD_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rsp_stb,
  input  logic [IDX_W-1:0]  rsp_idx,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic              idx_chk_en,
  input  logic              rd_end_stb,
  input  logic              rd_end_bit,
  input  logic              rd_crc_stb,
  input  logic              rd_crc_ok,
  input  logic              crcst_stb,
  input  logic [2:0]        crcst_tok,
  input  logic              crcst_end_bit,
  input  logic [3:0]        to_vec,
  input  logic [ACMD_W-1:0] acmd_err_vec,
  input  logic              dma_err_stb,
  input  logic              desc_stb,
  input  logic              desc_fetch_st,
  input  logic              desc_valid,
  output err_vec_t          set_c
);

  logic [ACMD_W-1:0] acmd_prev;
  logic [ACMD_W-1:0] acmd_rise;

  always_ff @(posedge clk) begin
    if (rst) acmd_prev <= '0;
    else     acmd_prev <= acmd_err_vec;
  end

  assign acmd_rise = acmd_err_vec & ~acmd_prev;

  always_comb begin
    set_c         = '0;
    set_c[E_CIDX] = rsp_stb & idx_chk_en & (rsp_idx != cmd_idx);
    set_c[E_TO]   = |to_vec;
    set_c[E_CRC]  = (rd_crc_stb & ~rd_crc_ok) |
                    (crcst_stb & (crcst_tok != CRCST_GOOD));
    set_c[E_END]  = (rd_end_stb & ~rd_end_bit) |
                    (crcst_stb & ~crcst_end_bit);
    set_c[E_ACMD] = |acmd_rise;
    set_c[E_DMA]  = dma_err_stb | (desc_stb & desc_fetch_st & ~desc_valid);
  end

endmodule

// File: rtl/sdh_w1c_bank.sv
module sdh_w1c_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;   // set beats clear
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/sdh_err_regs.sv
module sdh_err_regs
  import sdh_err_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     bus_wr,
  input  logic     bus_addr,
  input  word_t    bus_wdata,
  input  err_vec_t stat_c,
  output err_vec_t clr_c,
  output word_t    bus_rdata,
  output logic     irq
);

  err_vec_t mask_c;
  err_vec_t wdata_c;
  logic     unused_wbits;

  for (genvar i = 0; i < NERR; i++) begin : g_pick
    assign wdata_c[i] = bus_wdata[POS[i]];
  end

  assign unused_wbits = ^(bus_wdata & ~DEF_MASK);

  assign clr_c = (bus_wr && !bus_addr) ? wdata_c : '0;

  always_ff @(posedge clk) begin
    if (rst)                  mask_c <= '0;
    else if (bus_wr && bus_addr) mask_c <= wdata_c;
  end

  assign bus_rdata = bus_addr ? expand(mask_c) : expand(stat_c);
  assign irq       = |(stat_c & mask_c);

endmodule

// File: rtl/sdh_err_status.sv
module sdh_err_status
  import sdh_err_pkg::*;
#(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned ACMD_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic              rsp_stb,
  input  logic [IDX_W-1:0]  rsp_idx,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic              idx_chk_en,
  input  logic              rd_end_stb,
  input  logic              rd_end_bit,
  input  logic              rd_crc_stb,
  input  logic              rd_crc_ok,
  input  logic              crcst_stb,
  input  logic [2:0]        crcst_tok,
  input  logic              crcst_end_bit,
  input  logic              to_busy_rsp,
  input  logic              to_busy_wr,
  input  logic              to_crcst,
  input  logic              to_rd_data,
  input  logic [ACMD_W-1:0] acmd_err_vec,
  input  logic              dma_err_stb,
  input  logic              desc_stb,
  input  logic              desc_fetch_st,
  input  logic              desc_valid
);

  err_vec_t set_c;
  err_vec_t clr_c;
  err_vec_t stat_c;
  word_t    stat_word;

  sdh_err_detect #(.IDX_W(IDX_W), .ACMD_W(ACMD_W)) u_detect (
    .clk           (clk),
    .rst           (rst),
    .rsp_stb       (rsp_stb),
    .rsp_idx       (rsp_idx),
    .cmd_idx       (cmd_idx),
    .idx_chk_en    (idx_chk_en),
    .rd_end_stb    (rd_end_stb),
    .rd_end_bit    (rd_end_bit),
    .rd_crc_stb    (rd_crc_stb),
    .rd_crc_ok     (rd_crc_ok),
    .crcst_stb     (crcst_stb),
    .crcst_tok     (crcst_tok),
    .crcst_end_bit (crcst_end_bit),
    .to_vec        ({to_rd_data, to_crcst, to_busy_wr, to_busy_rsp}),
    .acmd_err_vec  (acmd_err_vec),
    .dma_err_stb   (dma_err_stb),
    .desc_stb      (desc_stb),
    .desc_fetch_st (desc_fetch_st),
    .desc_valid    (desc_valid),
    .set_c         (set_c)
  );

  sdh_w1c_bank #(.N(NERR)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .set_i (set_c),
    .clr_i (clr_c),
    .q_o   (stat_c)
  );

  sdh_err_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .stat_c    (stat_c),
    .clr_c     (clr_c),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  assign stat_word = expand(stat_c);

endmodule

// File: rtl/sdh_err_status_chk.sv
module sdh_err_status_chk
  import sdh_err_pkg::*;
#(
  parameter int unsigned ACMD_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              irq,
  input logic [ACMD_W-1:0] acmd_err_vec,
  input logic [NERR-1:0]   set_c,
  input logic [31:0]       stat_word
);

  // R2: a written 1 clears the bit unless an event set it that cycle
  p_w1c_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_addr) |=>
      ((stat_word & $past(bus_wdata) & ~$past(expand(set_c))) == '0));

  // R2: without a status write, no bit ever falls
  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && !bus_addr) |=>
      ((stat_word & $past(stat_word)) == $past(stat_word)));

  // R3: a steady auto-CMD12 vector cannot raise its bit
  p_acmd_level_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(acmd_err_vec)) |=> !$rose(stat_word[POS[E_ACMD]]));

  // R9: every set event is visible on the next cycle
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (|set_c) |=> ((stat_word & $past(expand(set_c))) == $past(expand(set_c))));

  // R10: an interrupt needs at least one status bit
  p_irq_src_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (stat_word != '0));

  // R11: the cycle after reset everything reads clear
  p_reset_clear_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stat_word == '0 && !irq));

endmodule

bind sdh_err_status sdh_err_status_chk #(.ACMD_W(ACMD_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .irq          (irq),
  .acmd_err_vec (acmd_err_vec),
  .set_c        (set_c),
  .stat_word    (stat_word)
);

// File: tb/sdh_err_status_bench.sv
module sdh_err_status_bench;

  localparam int IDX_W  = 6;
  localparam int ACMD_W = 5;

  localparam logic [31:0] B_CIDX = 32'h0008_0000;
  localparam logic [31:0] B_TO   = 32'h0010_0000;
  localparam logic [31:0] B_CRC  = 32'h0020_0000;
  localparam logic [31:0] B_END  = 32'h0040_0000;
  localparam logic [31:0] B_ACMD = 32'h0100_0000;
  localparam logic [31:0] B_DMA  = 32'h0200_0000;
  localparam logic [31:0] ALL    = 32'h0378_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_addr = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  logic rsp_stb = 0, idx_chk_en = 0;
  logic [IDX_W-1:0] rsp_idx = '0, cmd_idx = '0;
  logic rd_end_stb = 0, rd_end_bit = 1, rd_crc_stb = 0, rd_crc_ok = 1;
  logic crcst_stb = 0, crcst_end_bit = 1;
  logic [2:0] crcst_tok = 3'b010;
  logic to_busy_rsp = 0, to_busy_wr = 0, to_crcst = 0, to_rd_data = 0;
  logic [ACMD_W-1:0] acmd_err_vec = '0;
  logic dma_err_stb = 0, desc_stb = 0, desc_fetch_st = 0, desc_valid = 1;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  sdh_err_status #(.IDX_W(IDX_W), .ACMD_W(ACMD_W)) u_sdh_err_status (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_events();
    rsp_stb = 0; idx_chk_en = 0; rd_end_stb = 0; rd_end_bit = 1;
    rd_crc_stb = 0; rd_crc_ok = 1; crcst_stb = 0; crcst_tok = 3'b010;
    crcst_end_bit = 1; to_busy_rsp = 0; to_busy_wr = 0; to_crcst = 0;
    to_rd_data = 0; dma_err_stb = 0; desc_stb = 0; desc_fetch_st = 0;
    desc_valid = 1; bus_wr = 0; bus_addr = 0; bus_wdata = '0;
  endtask

  // events were set up after a negedge; let one edge pass, then drop them
  task automatic step();
    @(negedge clk);
    clear_events();
    #1;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
  endtask

  function automatic logic [31:0] rd_stat();
    return bus_rdata;
  endfunction

  task automatic rd_mask(output logic [31:0] v);
    bus_addr = 1; #1; v = bus_rdata; bus_addr = 0; #1;
  endtask

  task automatic t_reset();
    logic [31:0] m;
    chk("R11 status after reset", rd_stat(), '0);
    rd_mask(m);
    chk("R11 mask after reset", m, '0);
    chk("R11 irq after reset", {31'b0, irq}, '0);
  endtask

  task automatic t_cmd_idx();
    @(negedge clk); rsp_stb = 1; idx_chk_en = 0; rsp_idx = 6'd3; cmd_idx = 6'd5; step();
    chk("R7 mismatch with check off", rd_stat(), '0);
    @(negedge clk); rsp_stb = 1; idx_chk_en = 1; rsp_idx = 6'd5; cmd_idx = 6'd5; step();
    chk("R7 match with check on", rd_stat(), '0);
    @(negedge clk); rsp_stb = 1; idx_chk_en = 1; rsp_idx = 6'd4; cmd_idx = 6'd5; step();
    chk("R7 mismatch with check on", rd_stat(), B_CIDX);
  endtask

  task automatic t_w1c();
    wr(0, ~B_CIDX);
    chk("R2 write of zero keeps bit", rd_stat(), B_CIDX);
    repeat (3) @(negedge clk);
    chk("R2 bit stays without write", rd_stat(), B_CIDX);
    wr(0, B_CIDX);
    chk("R2 write one clears", rd_stat(), '0);
  endtask

  task automatic t_end_bit();
    @(negedge clk); rd_end_stb = 1; rd_end_bit = 1; step();
    chk("R4 good read end bit", rd_stat(), '0);
    @(negedge clk); rd_end_stb = 1; rd_end_bit = 0; step();
    chk("R4 bad read end bit", rd_stat(), B_END);
    wr(0, ALL);
    @(negedge clk); crcst_stb = 1; crcst_end_bit = 0; step();
    chk("R4 bad CRC status end bit", rd_stat(), B_END);
    wr(0, ALL);
  endtask

  task automatic t_crc();
    @(negedge clk); rd_crc_stb = 1; rd_crc_ok = 1; step();
    chk("R5 read CRC good", rd_stat(), '0);
    @(negedge clk); rd_crc_stb = 1; rd_crc_ok = 0; step();
    chk("R5 read CRC bad", rd_stat(), B_CRC);
    wr(0, ALL);
    @(negedge clk); crcst_stb = 1; crcst_tok = 3'b010; step();
    chk("R5 token 010 accepted", rd_stat(), '0);
    @(negedge clk); crcst_stb = 1; crcst_tok = 3'b101; step();
    chk("R5 token 101 rejected", rd_stat(), B_CRC);
    wr(0, ALL);
  endtask

  task automatic t_timeout();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      to_busy_rsp = (i == 0); to_busy_wr = (i == 1);
      to_crcst = (i == 2); to_rd_data = (i == 3);
      step();
      chk($sformatf("R6 timeout source %0d", i), rd_stat(), B_TO);
      wr(0, ALL);
    end
  endtask

  task automatic t_acmd();
    @(negedge clk); acmd_err_vec = 5'b00001; step();
    chk("R3 first rise sets", rd_stat(), B_ACMD);
    wr(0, B_ACMD);
    repeat (2) @(negedge clk);
    chk("R3 held level does not reset bit", rd_stat(), '0);
    @(negedge clk); acmd_err_vec = 5'b00101; step();
    chk("R3 new flag rise sets", rd_stat(), B_ACMD);
    wr(0, B_ACMD);
    @(negedge clk); acmd_err_vec = 5'b00100; step();
    chk("R3 falling flag ignored", rd_stat(), '0);
    @(negedge clk); acmd_err_vec = 5'b00000; step();
  endtask

  task automatic t_dma();
    @(negedge clk); dma_err_stb = 1; step();
    chk("R8 transfer error", rd_stat(), B_DMA);
    wr(0, ALL);
    @(negedge clk); desc_stb = 1; desc_fetch_st = 0; desc_valid = 0; step();
    chk("R8 invalid outside fetch ignored", rd_stat(), '0);
    @(negedge clk); desc_stb = 1; desc_fetch_st = 1; desc_valid = 1; step();
    chk("R8 valid in fetch", rd_stat(), '0);
    @(negedge clk); desc_stb = 1; desc_fetch_st = 1; desc_valid = 0; step();
    chk("R8 invalid in fetch", rd_stat(), B_DMA);
    wr(0, ALL);
  endtask

  task automatic t_set_wins();
    @(negedge clk);
    to_crcst = 1; bus_wr = 1; bus_addr = 0; bus_wdata = B_TO | B_CIDX;
    step();
    chk("R9 set beats same-cycle clear", rd_stat(), B_TO);
    wr(0, ALL);
  endtask

  task automatic t_mask_irq();
    logic [31:0] m;
    wr(1, 32'hFFFF_FFFF);
    rd_mask(m);
    chk("R10 mask keeps defined bits only", m, ALL);
    chk("R10 no irq without status", {31'b0, irq}, '0);
    wr(1, B_DMA);
    @(negedge clk); to_rd_data = 1; step();
    chk("R10 masked bit gives no irq", {31'b0, irq}, '0);
    @(negedge clk); dma_err_stb = 1; step();
    chk("R10 enabled bit raises irq", {31'b0, irq}, 32'd1);
    wr(0, B_DMA);
    chk("R10 irq drops after clear", {31'b0, irq}, '0);
    wr(0, ALL);
  endtask

  task automatic t_layout();
    wr(0, 32'hFFFF_FFFF);
    chk("R1 writes cannot set status", rd_stat(), '0);
    @(negedge clk);
    rsp_stb = 1; idx_chk_en = 1; rsp_idx = 6'd1; cmd_idx = 6'd2;
    rd_end_stb = 1; rd_end_bit = 0; rd_crc_stb = 1; rd_crc_ok = 0;
    to_busy_wr = 1; dma_err_stb = 1; acmd_err_vec = 5'b10000;
    step();
    chk("R1 all events, reserved bits zero", rd_stat(), ALL);
    chk("R1 bit 23 reads zero", {31'b0, bus_rdata[23]}, '0);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0; acmd_err_vec = '0; #1;
    chk("R11 reset clears status", rd_stat(), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; #1;
    t_reset();
    t_cmd_idx();
    t_w1c();
    t_end_bit();
    t_crc();
    t_timeout();
    t_acmd();
    t_dma();
    t_set_wins();
    t_mask_irq();
    t_layout();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule